// File: doc/BRIEF.md
# Stallable Sequential Fixed-Point Divider

This block divides a 16-bit or 32-bit dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder. Operands can be unsigned or two's complement. Integer and fractional (1.15) formats are both supported. One start pulse launches an operation. The operation always runs for the same number of cycles: one cycle conditions the operands, seventeen cycles each resolve one quotient bit, and one cycle fixes the signs and checks the range. The results then stay on the outputs until the next operation finishes.

A stall line freezes every register for as long as it is held. An enclosing pipeline can therefore suspend a divide at any cycle and resume it later with the same result. A zero divisor raises an error flag when done is asserted, and so does a quotient that cannot be represented in 16 bits. In both cases the quotient and remainder are reported as zero.

Top module: `seq_divider`

## Requirements
- R1: After a synchronous reset, busy, done, err, quotient and remainder are all 0.
- R2: A start accepted at a clock edge (idle, stall low) makes busy high for exactly 19 cycles when no stall occurs. In the cycle after busy falls, done is high for one cycle. The results stay unchanged after done falls.
- R3: With frac=0 and is_signed=0, the result is the unsigned quotient and remainder of the dividend divided by the divisor. wide=1 selects all 32 dividend bits. wide=0 uses dividend[15:0], and bits [31:16] have no effect.
- R4: With is_signed=1, both operands are two's complement. The quotient is truncated toward zero, its sign is the XOR of the operand signs, and the remainder carries the sign of the dividend.
- R5: With frac=1, dividend[15:0] is taken as a 1.15 value, and dividend[31:16] and wide are ignored. The quotient is (dividend[15:0] * 2^15) / divisor. The remainder is that of the scaled dividend. is_signed selects the signed or unsigned interpretation.
- R6: A zero divisor gives err=1 with quotient=0 and remainder=0.
- R7: A quotient outside the 16-bit range gives err=1 with quotient=0 and remainder=0. The unsigned range is 0..65535. The signed range is -32768..32767.
- R8: While stall is high, every register holds its value. Each stalled cycle during an operation lengthens busy by one cycle and leaves the result unchanged.
- R9: start has no effect while busy is high or while stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation when idle and not stalled |
| stall | input | 1 | Freeze all state while high |
| dividend | input | 32 | Dividend (low half only in narrow or fractional mode) |
| divisor | input | 16 | Divisor |
| wide | input | 1 | 1 selects a 32-bit integer dividend |
| is_signed | input | 1 | 1 selects two's-complement operands |
| frac | input | 1 | 1 selects 1.15 fractional division |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| err | output | 1 | Divide by zero or quotient overflow |

## Verification
The hardest situation to reach from the ports is a suspension that lands on a chosen internal phase, either the operand-conditioning cycle or the middle of the bit iterations. The bench reaches it by counting busy cycles after acceptance and raising stall at a chosen count for a chosen length. It then checks both the lengthened busy time and the unchanged result. Overflow that only shows up in the final range check is also hard to reach. It is driven with operands whose 17-bit quotient sets the top bit while passing the entry test, for example -2^31 / -2^15 and 1.0 / 0.5 in fractional mode.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int unsigned QW_DEF = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ITER  = 2'd2,
        PH_FIX   = 2'd3
    } phase_e;

    typedef struct packed {
        logic wide;
        logic sgn;
        logic frac;
    } mode_t;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int unsigned QW = QW_DEF
) (
    input  logic [2*QW-1:0] dvd,
    input  logic [QW-1:0]   dvs,
    input  mode_t           mode,
    output logic [QW-1:0]   rem0,
    output logic [QW:0]     shq0,
    output logic [QW-1:0]   dmag,
    output logic            q_neg,
    output logic            r_neg,
    output logic            dz,
    output logic            pre_ovf
);
    localparam int unsigned DW = 2 * QW;

    logic [DW-1:0] n_raw;
    logic [DW-1:0] nmag;
    logic          n_neg;
    logic          d_neg;

    // Select and align the effective dividend
    always_comb begin
        if (mode.frac) begin
            n_raw = {(mode.sgn & dvd[QW-1]), dvd[QW-1:0], {(QW-1){1'b0}}};
        end else if (mode.wide) begin
            n_raw = dvd;
        end else begin
            n_raw = {{QW{mode.sgn & dvd[QW-1]}}, dvd[QW-1:0]};
        end
    end

    assign n_neg = mode.sgn & n_raw[DW-1];
    assign d_neg = mode.sgn & dvs[QW-1];
    assign nmag  = n_neg ? (~n_raw + 1'b1) : n_raw;
    assign dmag  = d_neg ? (~dvs + 1'b1) : dvs;
    assign q_neg = n_neg ^ d_neg;
    assign r_neg = n_neg;
    assign dz    = (dvs == '0);

    // Upper bits seed the partial remainder; lower QW+1 bits are shifted in
    assign rem0    = {1'b0, nmag[DW-1:QW+1]};
    assign shq0    = nmag[QW:0];
    // Quotient needs more than QW+1 bits when the seed already reaches the divisor
    assign pre_ovf = !dz && (rem0 >= dmag);

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step
    import sdiv_pkg::*;
#(
    parameter int unsigned QW = QW_DEF
) (
    input  logic [QW-1:0] rem,
    input  logic [QW:0]   shq,
    input  logic [QW-1:0] dmag,
    output logic [QW-1:0] rem_n,
    output logic [QW:0]   shq_n
);
    logic [QW:0] trial;
    logic [QW:0] diff;
    logic        fits;

    assign trial = {rem, shq[QW]};
    assign diff  = trial - {1'b0, dmag};
    assign fits  = (trial >= {1'b0, dmag});
    assign rem_n = fits ? diff[QW-1:0] : trial[QW-1:0];
    assign shq_n = {shq[QW-1:0], fits};

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
    import sdiv_pkg::*;
#(
    parameter int unsigned QW = QW_DEF
) (
    input  logic [QW:0]   qmag,
    input  logic [QW-1:0] rmag,
    input  logic          q_neg,
    input  logic          r_neg,
    input  logic          sgn,
    input  logic          flag_in,
    output logic [QW-1:0] quo,
    output logic [QW-1:0] rem,
    output logic          err
);
    localparam logic [QW:0] HALF = {2'b01, {(QW-1){1'b0}}};

    logic in_range;

    always_comb begin
        if (sgn) begin
            in_range = q_neg ? (qmag <= HALF) : (qmag < HALF);
        end else begin
            in_range = !qmag[QW];
        end
    end

    assign err = flag_in | !in_range;
    assign quo = err ? '0 : (q_neg ? (~qmag[QW-1:0] + 1'b1) : qmag[QW-1:0]);
    assign rem = err ? '0 : (r_neg ? (~rmag + 1'b1) : rmag);

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import sdiv_pkg::*;
#(
    parameter int unsigned QW = QW_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        stall,
    input  logic [31:0] dividend,
    input  logic [15:0] divisor,
    input  logic        wide,
    input  logic        is_signed,
    input  logic        frac,
    output logic        busy,
    output logic        done,
    output logic [15:0] quotient,
    output logic [15:0] remainder,
    output logic        err
);
    localparam int unsigned DW    = 2 * QW;
    localparam int unsigned STEPS = QW + 1;
    localparam int unsigned CW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] dvd_q;
    logic [QW-1:0] dvs_q;
    mode_t         mode_q;
    logic [QW-1:0] rem_q;
    logic [QW:0]   shq_q;
    logic [QW-1:0] dmag_q;
    logic          qneg_q, rneg_q, flag_q;
    logic [QW-1:0] quo_q, remo_q;
    logic          err_q, done_q;

    logic [QW-1:0] p_rem0, p_dmag, s_rem, f_quo, f_rem;
    logic [QW:0]   p_shq0, s_shq;
    logic          p_qneg, p_rneg, p_dz, p_ovf, f_err;

    sdiv_prep #(.QW(QW)) prep_i (
        .dvd(dvd_q), .dvs(dvs_q), .mode(mode_q),
        .rem0(p_rem0), .shq0(p_shq0), .dmag(p_dmag),
        .q_neg(p_qneg), .r_neg(p_rneg), .dz(p_dz), .pre_ovf(p_ovf)
    );

    sdiv_step #(.QW(QW)) step_i (
        .rem(rem_q), .shq(shq_q), .dmag(dmag_q),
        .rem_n(s_rem), .shq_n(s_shq)
    );

    sdiv_fix #(.QW(QW)) fix_i (
        .qmag(shq_q), .rmag(rem_q), .q_neg(qneg_q), .r_neg(rneg_q),
        .sgn(mode_q.sgn), .flag_in(flag_q),
        .quo(f_quo), .rem(f_rem), .err(f_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            dvd_q   <= '0;
            dvs_q   <= '0;
            mode_q  <= '0;
            rem_q   <= '0;
            shq_q   <= '0;
            dmag_q  <= '0;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            flag_q  <= 1'b0;
            quo_q   <= '0;
            remo_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (!stall) begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        dvd_q   <= DW'(dividend);
                        dvs_q   <= QW'(divisor);
                        mode_q  <= '{wide: wide, sgn: is_signed, frac: frac};
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    rem_q   <= p_rem0;
                    shq_q   <= p_shq0;
                    dmag_q  <= p_dmag;
                    qneg_q  <= p_qneg;
                    rneg_q  <= p_rneg;
                    flag_q  <= p_dz | p_ovf;
                    cnt_q   <= '0;
                    phase_q <= PH_ITER;
                end
                PH_ITER: begin
                    rem_q <= s_rem;
                    shq_q <= s_shq;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) phase_q <= PH_FIX;
                end
                PH_FIX: begin
                    quo_q   <= f_quo;
                    remo_q  <= f_rem;
                    err_q   <= f_err;
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign quotient  = 16'(quo_q);
    assign remainder = 16'(remo_q);
    assign err       = err_q;

    // R8: a stalled edge changes nothing
    p_stall_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (stall && !$past(rst)) |=> ($stable(phase_q) && $stable(cnt_q) && $stable(rem_q)
                          && $stable(shq_q) && $stable(quo_q) && $stable(done_q)))
        else $error("stall did not freeze state");

    // R9: idle without an accepted start stays idle
    p_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !(start && !stall)) |=> (phase_q == PH_IDLE))
        else $error("operation began without an accepted start");

    // R9: a running operation is not cut short by start
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && phase_q != PH_FIX) |=> busy)
        else $error("busy dropped before the final phase");

    // R2: done only follows the final phase and never overlaps busy
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("done overlapped busy");

    // R3: partial remainder stays below the divisor in a valid operation
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ITER && !flag_q) |-> (rem_q < dmag_q))
        else $error("partial remainder reached divisor");

    // R6: an error result carries zero quotient and remainder
    p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (quotient == '0 && remainder == '0))
        else $error("error result not zeroed");

endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        wide = 1'b0, is_signed = 1'b0, frac = 1'b0;
    logic        busy, done, err;
    logic [15:0] quotient, remainder;

    int n_cmp = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    seq_divider dut_i (
        .clk(clk), .rst(rst), .start(start), .stall(stall),
        .dividend(dividend), .divisor(divisor),
        .wide(wide), .is_signed(is_signed), .frac(frac),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .err(err)
    );

    typedef struct packed {
        logic        w;
        logic        s;
        logic        f;
        logic [31:0] a;
        logic [15:0] b;
        logic [15:0] q;
        logic [15:0] r;
        logic        e;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0,1'b0,1'b0, 32'hABCD0064, 16'h0007, 16'h000E, 16'h0002, 1'b0, 4'd3}, // R3 upper bits ignored
        '{1'b0,1'b0,1'b0, 32'h0000FFFF, 16'h0001, 16'hFFFF, 16'h0000, 1'b0, 4'd3}, // R3
        '{1'b1,1'b0,1'b0, 32'h00010000, 16'h0002, 16'h8000, 16'h0000, 1'b0, 4'd3}, // R3
        '{1'b1,1'b0,1'b0, 32'h00FFFFFF, 16'h0100, 16'hFFFF, 16'h00FF, 1'b0, 4'd3}, // R3
        '{1'b1,1'b0,1'b0, 32'h12345678, 16'h1234, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 17-bit quotient
        '{1'b1,1'b0,1'b0, 32'hFFFFFFFF, 16'h0001, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 far out of range
        '{1'b0,1'b1,1'b0, 32'h0000FF9C, 16'h0007, 16'hFFF2, 16'hFFFE, 1'b0, 4'd4}, // R4 -100/7
        '{1'b0,1'b1,1'b0, 32'h00000064, 16'hFFF9, 16'hFFF2, 16'h0002, 1'b0, 4'd4}, // R4 100/-7
        '{1'b0,1'b1,1'b0, 32'h0000FF9C, 16'hFFF9, 16'h000E, 16'hFFFE, 1'b0, 4'd4}, // R4 -100/-7
        '{1'b1,1'b1,1'b0, 32'hFFFFFF9C, 16'h0007, 16'hFFF2, 16'hFFFE, 1'b0, 4'd4}, // R4 wide
        '{1'b1,1'b1,1'b0, 32'hFFFF0000, 16'h0002, 16'h8000, 16'h0000, 1'b0, 4'd7}, // R7 -32768 fits
        '{1'b1,1'b1,1'b0, 32'h00010000, 16'h0002, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 +32768
        '{1'b0,1'b1,1'b0, 32'h00008000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 -32768/-1
        '{1'b1,1'b1,1'b0, 32'h80000000, 16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 late range check
        '{1'b0,1'b0,1'b0, 32'h00000005, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd6}, // R6
        '{1'b1,1'b1,1'b0, 32'h80000000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd6}, // R6 signed
        '{1'b0,1'b0,1'b1, 32'h00004000, 16'h8000, 16'h4000, 16'h0000, 1'b0, 4'd5}, // R5 unsigned
        '{1'b0,1'b1,1'b1, 32'h00002000, 16'h4000, 16'h4000, 16'h0000, 1'b0, 4'd5}, // R5 0.25/0.5
        '{1'b0,1'b1,1'b1, 32'h0000E000, 16'h4000, 16'hC000, 16'h0000, 1'b0, 4'd5}, // R5 negative
        '{1'b0,1'b1,1'b1, 32'h00004000, 16'h6000, 16'h5555, 16'h2000, 1'b0, 4'd5}, // R5 remainder
        '{1'b1,1'b0,1'b1, 32'hFFFF4000, 16'h8000, 16'h4000, 16'h0000, 1'b0, 4'd5}, // R5 upper and wide ignored
        '{1'b0,1'b1,1'b1, 32'h00008000, 16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd7}, // R7 -1.0/-1.0
        '{1'b0,1'b0,1'b1, 32'h00008000, 16'h4000, 16'h0000, 16'h0000, 1'b1, 4'd7}  // R7 1.0/0.5 unsigned
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic w, input logic s, input logic f,
                          input logic [31:0] a, input logic [15:0] b,
                          input int st_at, input int st_len,
                          output int nbusy);
        @(negedge clk);
        wide = w; is_signed = s; frac = f;
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nbusy = 0;
        while (busy && nbusy < 400) begin
            nbusy++;
            if (nbusy == st_at) stall = 1'b1;
            if (nbusy == st_at + st_len) stall = 1'b0;
            @(negedge clk);
        end
        stall = 1'b0;
    endtask

    initial begin
        #2ms;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int nb;
        logic [15:0] q_keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "err", 32'(err), 0);
        chk("R1", "quotient", 32'(quotient), 0);
        chk("R1", "remainder", 32'(remainder), 0);

        // Vector table: R3 R4 R5 R6 R7, each also timed for R2
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d", VEC[i].tag);
            run_op(VEC[i].w, VEC[i].s, VEC[i].f, VEC[i].a, VEC[i].b, 0, 0, nb);
            chk("R2", $sformatf("busy cycles v%0d", i), 32'(nb), 19);
            chk("R2", $sformatf("done v%0d", i), 32'(done), 1);
            chk(tg, $sformatf("quotient v%0d", i), 32'(quotient), 32'(VEC[i].q));
            chk(tg, $sformatf("remainder v%0d", i), 32'(remainder), 32'(VEC[i].r));
            chk(tg, $sformatf("err v%0d", i), 32'(err), 32'(VEC[i].e));
        end

        // R2 done is a single pulse and results persist
        run_op(1'b0, 1'b0, 1'b0, 32'h0000_03E8, 16'h000A, 0, 0, nb);
        @(negedge clk);
        chk("R2", "done pulse width", 32'(done), 0);
        chk("R2", "held quotient", 32'(quotient), 32'h64);
        repeat (5) @(negedge clk);
        chk("R2", "held remainder", 32'(remainder), 0);

        // R8 stall in the middle of the iterations
        run_op(1'b1, 1'b0, 1'b0, 32'h00FF_FFFF, 16'h0100, 6, 7, nb);
        chk("R8", "busy with mid stall", 32'(nb), 26);
        chk("R8", "quotient mid stall", 32'(quotient), 32'hFFFF);
        chk("R8", "remainder mid stall", 32'(remainder), 32'h00FF);

        // R8 stall on the conditioning cycle
        run_op(1'b0, 1'b1, 1'b0, 32'h0000_FF9C, 16'h0007, 1, 3, nb);
        chk("R8", "busy with setup stall", 32'(nb), 22);
        chk("R8", "quotient setup stall", 32'(quotient), 32'hFFF2);
        chk("R8", "remainder setup stall", 32'(remainder), 32'hFFFE);

        // R8 stall right before the final phase, then the done edge frozen
        run_op(1'b0, 1'b0, 1'b0, 32'h0000_0064, 16'h0007, 19, 4, nb);
        chk("R8", "busy with late stall", 32'(nb), 23);
        chk("R8", "quotient late stall", 32'(quotient), 32'h000E);
        stall = 1'b1;
        @(negedge clk);
        chk("R8", "done held by stall", 32'(done), 1);
        stall = 1'b0;
        @(negedge clk);
        chk("R8", "done after stall", 32'(done), 0);

        // R9 start while busy is ignored
        @(negedge clk);
        wide = 1'b0; is_signed = 1'b0; frac = 1'b0;
        dividend = 32'd200; divisor = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 1;
        repeat (3) begin @(negedge clk); nb++; end
        dividend = 32'd7; divisor = 16'd1; start = 1'b1;
        repeat (3) begin @(negedge clk); nb++; end
        start = 1'b0;
        while (busy && nb < 400) begin @(negedge clk); nb++; end
        chk("R9", "busy with start in flight", 32'(nb), 20);
        chk("R9", "quotient with start in flight", 32'(quotient), 32'd22);
        chk("R9", "remainder with start in flight", 32'(remainder), 32'd2);

        // R9 start while stalled and idle is ignored
        q_keep = quotient;
        stall = 1'b1;
        dividend = 32'd9; divisor = 16'd3; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        stall = 1'b0;
        @(negedge clk);
        chk("R9", "busy after stalled start", 32'(busy), 0);
        chk("R9", "quotient after stalled start", 32'(quotient), 32'(q_keep));

        // R1 reset in the middle of an operation
        @(negedge clk);
        dividend = 32'd500; divisor = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy after mid reset", 32'(busy), 0);
        chk("R1", "quotient after mid reset", 32'(quotient), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule